// File: doc/BRIEF.md
# Quad DAC Register Update Controller

This block keeps the digital state behind four 16-bit converter channels. Each channel has a staging register that accepts new codes and an output register whose value goes to the converter. Frames arrive already deserialized as 32-bit words with a one-cycle `frameValid` strobe. Each frame carries a command, a channel address and a payload. Three pins act alongside the frames. An active-low load pin moves staged codes into the output registers. An active-low clear pin forces a programmable code onto every channel. A preset-select pin chooses the code used after reset. The block also records a 2-bit output-termination mode for each channel, which the analog side reads.

Software can mark individual channels so that they behave as if the load pin were held low, while the other channels stay under pin control. A clear event is taken on the falling edge of the clear pin, not on its level. While the clear pin stays low, the load pin's edges are not acted on. A reset comes from the `rstN` input or from a reset command. It returns both registers of every channel to zero scale or midscale, whichever the preset-select pin chooses.

All state changes on the rising clock edge. The pins are sampled synchronously, and their edges are found by comparing each pin with its value on the previous cycle.

Top module: `quadDacUpdater`

## Requirements
- R1: While `rstN` is low, and on the edge that takes a reset command (cmd 0111), every staging and output register takes 0x8000 if `presetMid` is 1 and 0x0000 otherwise. In the same case every power mode, the clear code and all override bits return to 0.
- R2: Command 0000 writes the payload code (frame bits 19:4) to the staging register of the addressed channel. If `loadN` is high and that channel's override bit is 0, its output register does not change.
- R3: If `loadN` is low during command 0000, the output register of the addressed channel takes the new code on that same edge.
- R4: Command 0001 copies staging to output for the addressed channel. Command 0011 writes staging and output of the addressed channel. Command 0010 writes the addressed staging register and then copies all four staging registers, including the new code, into their output registers. All three ignore `loadN`.
- R5: When `loadN` falls (high on one sampled cycle, low on the next), every staging register is copied to its output register. This does not happen while `clearN` is low.
- R6: Command 0110 loads the override bits from frame bits 3:0 (bit 0 is channel A, bit 3 is channel D). A channel whose override bit is 1 acts under command 0000 as if `loadN` were low.
- R7: Command 0101 loads the clear code from frame bits 1:0. When `clearN` falls, both registers of all channels take 0x0000 (code 00), 0x8000 (code 01) or 0xFFFF (code 10). Code 11 does nothing. In the same cycle, a clear overrides any frame write to those registers.
- R8: Command 0100 gives the mode in frame bits 9:8 to each channel whose bit in frame bits 3:0 is 1. The modes are 00 normal, 01 1 kΩ to ground, 10 100 kΩ to ground and 11 high impedance. Output codes are kept while a channel is powered down.
- R9: Address field bits 23:20 select channel A to D with the values 0 to 3, and all channels with 0xF. A command 0000 to 0011 frame that carries any other address changes nothing.
- R10: Command codes 1000 to 1111 change no state.
- R11: On the edge that takes a reset command, a `clearN` or `loadN` falling edge in that same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| frameValid | input | 1 | Marks a complete frame on `frameData` for one cycle |
| frameData | input | 32 | Frame: cmd 27:24, address 23:20, code 19:4 |
| loadN | input | 1 | Active-low load pin |
| clearN | input | 1 | Clear pin, acts on its falling edge |
| presetMid | input | 1 | Reset to midscale when 1, to zero when 0 |
| dacCode | output | NUM_CH*16 | Output register codes, channel A in bits 15:0 |
| pwrMode | output | NUM_CH*2 | Power mode per channel, channel A in bits 1:0 |

## Verification
Two pairs of functions can act in one cycle. The first is a clear-pin falling edge arriving with a frame that writes data. The clear code must win on both registers, while a power or override command in that frame still takes effect. The second is a load-pin falling edge arriving with a staging write. The copy must carry the newly written code. Directed cycles set up each collision on purpose, and the random phase toggles the pins freely while frames flow, so more cases occur there. A bench model applies the priority order reset, then clear, then write-then-copy, and every output is compared with it after each edge.

// File: rtl/qdacPkg.sv
package qdacPkg;
  localparam int FRAME_W  = 32;
  localparam int CODE_W   = 16;
  localparam int MAX_CH   = 4;
  localparam int CMD_LSB  = 24;
  localparam int ADDR_LSB = 20;
  localparam int CODE_LSB = 4;
  localparam int PWR_LSB  = 8;

  localparam logic [3:0] CMD_WR_IN      = 4'h0;
  localparam logic [3:0] CMD_IN_TO_OUT  = 4'h1;
  localparam logic [3:0] CMD_WR_UPD_ALL = 4'h2;
  localparam logic [3:0] CMD_WR_UPD     = 4'h3;
  localparam logic [3:0] CMD_PWR        = 4'h4;
  localparam logic [3:0] CMD_CLR_CODE   = 4'h5;
  localparam logic [3:0] CMD_OVERRIDE   = 4'h6;
  localparam logic [3:0] CMD_RESET      = 4'h7;
  localparam logic [3:0] ADDR_ALL       = 4'hF;

  localparam logic [CODE_W-1:0] CODE_ZERO = 16'h0000;
  localparam logic [CODE_W-1:0] CODE_MID  = 16'h8000;
  localparam logic [CODE_W-1:0] CODE_FULL = 16'hFFFF;

  // strobes handed from control to datapath, one cycle each
  typedef struct packed {
    logic              doReset;
    logic [CODE_W-1:0] resetVal;
    logic              doClear;
    logic [CODE_W-1:0] clearVal;
    logic [MAX_CH-1:0] wrIn;
    logic [CODE_W-1:0] wrData;
    logic [MAX_CH-1:0] upd;
    logic [MAX_CH-1:0] pwrWr;
    logic [1:0]        pwrVal;
  } strobeT;
endpackage

// File: rtl/dacCtrl.sv
module dacCtrl
  import qdacPkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameValid,
  input  logic [FRAME_W-1:0] frameData,
  input  logic               loadN,
  input  logic               clearN,
  input  logic               presetMid,
  output strobeT             stb
);
  localparam logic [3:0]        NUM_CH4  = 4'(NUM_CH);
  localparam logic [MAX_CH-1:0] ALL_MASK = MAX_CH'((1 << NUM_CH) - 1);

  logic [3:0]        cmd;
  logic [3:0]        addr;
  logic [MAX_CH-1:0] chSel;
  logic [MAX_CH-1:0] effLoad;
  logic [MAX_CH-1:0] ovrFull;
  logic [1:0]        clrCode;
  logic [NUM_CH-1:0] ovr;
  logic              ldPrev;
  logic              clrPrev;
  logic              isRst;
  logic              clrEdge;
  logic              ldEdge;

  assign cmd     = frameData[CMD_LSB +: 4];
  assign addr    = frameData[ADDR_LSB +: 4];
  assign isRst   = frameValid && (cmd == CMD_RESET);
  assign clrEdge = clrPrev && !clearN;
  assign ldEdge  = ldPrev && !loadN && clearN;
  assign ovrFull = MAX_CH'(ovr);
  assign effLoad = {MAX_CH{!loadN}} | ovrFull;

  always_comb begin
    chSel = '0;
    if (addr == ADDR_ALL) chSel = ALL_MASK;
    else if (addr < NUM_CH4) chSel[addr[1:0]] = 1'b1;
  end

  always_comb begin
    stb          = '0;
    stb.doReset  = !rstN || isRst;
    stb.resetVal = presetMid ? CODE_MID : CODE_ZERO;
    stb.wrData   = frameData[CODE_LSB +: CODE_W];
    stb.pwrVal   = frameData[PWR_LSB +: 2];
    stb.doClear  = clrEdge && (clrCode != 2'b11) && !isRst;
    unique case (clrCode)
      2'b01:   stb.clearVal = CODE_MID;
      2'b10:   stb.clearVal = CODE_FULL;
      default: stb.clearVal = CODE_ZERO;
    endcase
    if (frameValid) begin
      unique case (cmd)
        CMD_WR_IN: begin
          stb.wrIn = chSel;
          stb.upd  = chSel & effLoad;
        end
        CMD_IN_TO_OUT: stb.upd = chSel;
        CMD_WR_UPD_ALL: begin
          stb.wrIn = chSel;
          stb.upd  = (|chSel) ? ALL_MASK : '0;
        end
        CMD_WR_UPD: begin
          stb.wrIn = chSel;
          stb.upd  = chSel;
        end
        CMD_PWR: stb.pwrWr = frameData[MAX_CH-1:0] & ALL_MASK;
        default: ;
      endcase
    end
    if (ldEdge && !isRst) stb.upd = ALL_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clrCode <= 2'b00;
      ovr     <= '0;
      ldPrev  <= 1'b0;
      clrPrev <= 1'b0;
    end else begin
      ldPrev  <= loadN;
      clrPrev <= clearN;
      if (isRst) begin
        clrCode <= 2'b00;
        ovr     <= '0;
      end else if (frameValid && cmd == CMD_CLR_CODE) begin
        clrCode <= frameData[1:0];
      end else if (frameValid && cmd == CMD_OVERRIDE) begin
        ovr <= frameData[NUM_CH-1:0];
      end
    end
  end
endmodule

// File: rtl/dacDatapath.sv
module dacDatapath
  import qdacPkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                     clk,
  input  strobeT                   stb,
  output logic [NUM_CH*CODE_W-1:0] dacCode,
  output logic [NUM_CH*2-1:0]      pwrMode
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CODE_W-1:0] inReg;
    logic [CODE_W-1:0] outReg;
    logic [1:0]        pwr;
    logic [CODE_W-1:0] nextIn;

    // write lands first so a same-cycle copy carries the new code
    assign nextIn = stb.wrIn[c] ? stb.wrData : inReg;

    always_ff @(posedge clk) begin
      if (stb.doReset) begin
        inReg  <= stb.resetVal;
        outReg <= stb.resetVal;
        pwr    <= 2'b00;
      end else begin
        if (stb.doClear) begin
          inReg  <= stb.clearVal;
          outReg <= stb.clearVal;
        end else begin
          inReg <= nextIn;
          if (stb.upd[c]) outReg <= nextIn;
        end
        if (stb.pwrWr[c]) pwr <= stb.pwrVal;
      end
    end

    assign dacCode[c*CODE_W +: CODE_W] = outReg;
    assign pwrMode[c*2 +: 2]           = pwr;
  end
endmodule

// File: rtl/quadDacUpdater.sv
module quadDacUpdater #(
  parameter int NUM_CH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameValid,
  input  logic [31:0]        frameData,
  input  logic               loadN,
  input  logic               clearN,
  input  logic               presetMid,
  output logic [NUM_CH*16-1:0] dacCode,
  output logic [NUM_CH*2-1:0]  pwrMode
);
  qdacPkg::strobeT stb;

  dacCtrl #(.NUM_CH(NUM_CH)) i_ctrl (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameData(frameData),
    .loadN(loadN), .clearN(clearN), .presetMid(presetMid), .stb(stb)
  );

  dacDatapath #(.NUM_CH(NUM_CH)) i_dp (
    .clk(clk), .stb(stb), .dacCode(dacCode), .pwrMode(pwrMode)
  );
endmodule

// File: rtl/quadDacChecker.sv
module quadDacChecker #(
  parameter int NUM_CH = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 frameValid,
  input logic [31:0]          frameData,
  input logic                 loadN,
  input logic                 clearN,
  input logic                 presetMid,
  input logic [NUM_CH*16-1:0] dacCode,
  input logic [NUM_CH*2-1:0]  pwrMode
);
  logic [3:0] cmd;
  logic [3:0] addr;
  assign cmd  = frameData[27:24];
  assign addr = frameData[23:20];

  // R1
  reset_pwr_chk: assert property (@(posedge clk) !rstN |=> (pwrMode == '0));

  // R1
  reset_code_chk: assert property (@(posedge clk)
    !rstN |=> (dacCode[15:0] == ($past(presetMid) ? 16'h8000 : 16'h0000)));

  // R8
  pwr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(frameValid && (cmd == 4'h4 || cmd == 4'h7)) |=> $stable(pwrMode));

  // R5
  clear_low_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clearN && $past(!clearN) && !frameValid) |=> $stable(dacCode));

  // R10
  reserved_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && cmd[3] && $stable(loadN) && $stable(clearN)) |=> $stable(dacCode));

  // R9
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && cmd == 4'h3 && addr >= 4'h4 && addr != 4'hF
     && $stable(loadN) && $stable(clearN)) |=> $stable(dacCode));
endmodule

bind quadDacUpdater quadDacChecker #(.NUM_CH(NUM_CH)) i_chk (.*);

// File: tb/test_quadDacUpdater.sv
module test_quadDacUpdater;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameValid = 1'b0;
  logic [31:0] frameData = '0;
  logic        loadN = 1'b1;
  logic        clearN = 1'b1;
  logic        presetMid = 1'b0;
  logic [63:0] dacCode;
  logic [7:0]  pwrMode;

  int checks = 0;
  int fails  = 0;

  logic [15:0] mIn [4];
  logic [15:0] mOut[4];
  logic [1:0]  mPw [4];
  logic [1:0]  mClr;
  logic [3:0]  mOvr;
  logic        mLdP;
  logic        mClP;

  always #2 clk = ~clk;

  quadDacUpdater i_quadDacUpdater (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameData(frameData),
    .loadN(loadN), .clearN(clearN), .presetMid(presetMid),
    .dacCode(dacCode), .pwrMode(pwrMode)
  );

  function automatic logic [31:0] mkFrame(logic [3:0] c, logic [3:0] a, logic [19:0] low);
    return {4'h0, c, a, low};
  endfunction

  function automatic logic [31:0] mkWrite(logic [3:0] c, logic [3:0] a, logic [15:0] code);
    return {4'h0, c, a, code, 4'h0};
  endfunction

  function automatic logic [3:0] selMask(logic [3:0] a);
    if (a == 4'hF) return 4'hF;
    if (a < 4'h4) return 4'(1 << a);
    return 4'h0;
  endfunction

  function automatic logic [15:0] clrValue(logic [1:0] k);
    case (k)
      2'b01:   return 16'h8000;
      2'b10:   return 16'hFFFF;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic presetAll(logic pm);
    for (int c = 0; c < 4; c++) begin
      mIn[c]  = pm ? 16'h8000 : 16'h0000;
      mOut[c] = mIn[c];
      mPw[c]  = 2'b00;
    end
    mClr = 2'b00;
    mOvr = 4'h0;
  endtask

  task automatic modelStep;
    logic [3:0]  cmd, sel, upd, wr;
    logic [15:0] code;
    logic        clrE, ldE;
    logic [15:0] staged[4];
    cmd  = frameData[27:24];
    sel  = selMask(frameData[23:20]);
    code = frameData[19:4];
    if (!rstN) begin
      presetAll(presetMid);
      mLdP = 1'b0; mClP = 1'b0;
      return;
    end
    if (frameValid && cmd == 4'h7) begin
      presetAll(presetMid);
      mLdP = loadN; mClP = clearN;
      return;
    end
    clrE = mClP && !clearN;
    ldE  = mLdP && !loadN && clearN;
    wr = 4'h0; upd = 4'h0;
    if (frameValid) begin
      case (cmd)
        4'h0: begin wr = sel; upd = sel & ({4{!loadN}} | mOvr); end
        4'h1: upd = sel;
        4'h2: begin wr = sel; upd = (sel != 0) ? 4'hF : 4'h0; end
        4'h3: begin wr = sel; upd = sel; end
        default: ;
      endcase
    end
    if (ldE) upd = 4'hF;
    for (int c = 0; c < 4; c++) staged[c] = wr[c] ? code : mIn[c];
    if (clrE && mClr != 2'b11) begin
      for (int c = 0; c < 4; c++) begin
        mIn[c] = clrValue(mClr); mOut[c] = clrValue(mClr);
      end
    end else begin
      for (int c = 0; c < 4; c++) begin
        mIn[c] = staged[c];
        if (upd[c]) mOut[c] = staged[c];
      end
    end
    if (frameValid && cmd == 4'h4)
      for (int c = 0; c < 4; c++) if (frameData[c]) mPw[c] = frameData[9:8];
    if (frameValid && cmd == 4'h5) mClr = frameData[1:0];
    if (frameValid && cmd == 4'h6) mOvr = frameData[3:0];
    mLdP = loadN; mClP = clearN;
  endtask

  task automatic compareAll(string tag);
    logic [63:0] expCode;
    logic [7:0]  expPw;
    for (int c = 0; c < 4; c++) begin
      expCode[c*16 +: 16] = mOut[c];
      expPw[c*2 +: 2]     = mPw[c];
    end
    checks++;
    if (dacCode !== expCode || pwrMode !== expPw) begin
      fails++;
      $display("FAIL %s codes=%h pwr=%h expected codes=%h pwr=%h", tag, dacCode, pwrMode, expCode, expPw);
    end
  endtask

  task automatic expectEq(logic [15:0] act, logic [15:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at the falling edge, compare 1 ns after the rising edge
  task automatic cyc(logic v, logic [31:0] d, string tag);
    @(negedge clk);
    frameValid = v;
    frameData  = d;
    modelStep();
    @(posedge clk);
    #1;
    compareAll(tag);
  endtask

  function automatic string tagOf(logic [3:0] c);
    case (c)
      4'h0: return "R2";
      4'h1, 4'h2, 4'h3: return "R4";
      4'h4: return "R8";
      4'h5: return "R7";
      4'h6: return "R6";
      4'h7: return "R11";
      default: return "R10";
    endcase
  endfunction

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    // R1 reset to midscale
    presetMid = 1'b1; rstN = 1'b0;
    repeat (3) cyc(1'b0, '0, "R1");
    expectEq(dacCode[15:0], 16'h8000, "R1");
    rstN = 1'b1;
    cyc(1'b0, '0, "R1");

    // R2 staging write held off, then R4 transfer
    cyc(1'b1, mkWrite(4'h0, 4'h0, 16'h1234), "R2");
    expectEq(dacCode[15:0], 16'h8000, "R2");
    cyc(1'b1, mkWrite(4'h1, 4'h0, 16'h0000), "R4");
    expectEq(dacCode[15:0], 16'h1234, "R4");

    // R3 load pin low while the frame completes
    loadN = 1'b0;
    cyc(1'b1, mkWrite(4'h0, 4'h1, 16'hBEEF), "R3");
    expectEq(dacCode[31:16], 16'hBEEF, "R3");
    loadN = 1'b1;
    cyc(1'b0, '0, "R3");

    // R5 falling load edge in the same cycle as a staging write
    cyc(1'b1, mkWrite(4'h0, 4'h2, 16'h0C0C), "R5");
    loadN = 1'b0;
    cyc(1'b1, mkWrite(4'h0, 4'h3, 16'h0D0D), "R5");
    expectEq(dacCode[47:32], 16'h0C0C, "R5");
    expectEq(dacCode[63:48], 16'h0D0D, "R5");
    loadN = 1'b1;
    cyc(1'b1, mkWrite(4'h0, 4'h2, 16'h7777), "R5");
    clearN = 1'b0;
    cyc(1'b0, '0, "R7");
    loadN = 1'b0;
    cyc(1'b0, '0, "R5");
    expectEq(dacCode[47:32], 16'h0000, "R5");
    loadN = 1'b1; clearN = 1'b1;
    cyc(1'b0, '0, "R5");

    // R7 clear code full scale, then no-op code, then clear against a write
    cyc(1'b1, mkFrame(4'h5, 4'h0, 20'h2), "R7");
    clearN = 1'b0;
    cyc(1'b0, '0, "R7");
    expectEq(dacCode[31:16], 16'hFFFF, "R7");
    clearN = 1'b1;
    cyc(1'b1, mkFrame(4'h5, 4'h0, 20'h3), "R7");
    cyc(1'b1, mkWrite(4'h3, 4'h0, 16'h4444), "R7");
    clearN = 1'b0;
    cyc(1'b1, mkWrite(4'h3, 4'h1, 16'h5555), "R7");
    expectEq(dacCode[15:0], 16'h4444, "R7");
    clearN = 1'b1;
    cyc(1'b1, mkFrame(4'h5, 4'h0, 20'h1), "R7");
    clearN = 1'b0;
    cyc(1'b1, mkWrite(4'h3, 4'h2, 16'h6666), "R7");
    expectEq(dacCode[47:32], 16'h8000, "R7");
    clearN = 1'b1;

    // R6 override on channel A
    cyc(1'b1, mkFrame(4'h6, 4'h0, 20'h1), "R6");
    cyc(1'b1, mkWrite(4'h0, 4'h0, 16'hA5A5), "R6");
    expectEq(dacCode[15:0], 16'hA5A5, "R6");
    cyc(1'b1, mkWrite(4'h0, 4'h1, 16'h5A5A), "R6");
    expectEq(dacCode[31:16], 16'h8000, "R6");

    // R8 power modes, codes kept
    cyc(1'b1, mkFrame(4'h4, 4'h0, 20'h305), "R8");
    expectEq({8'h0, pwrMode}, 16'h0033, "R8");
    expectEq(dacCode[15:0], 16'hA5A5, "R8");

    // R9 address decode
    cyc(1'b1, mkWrite(4'h3, 4'h5, 16'h1111), "R9");
    cyc(1'b1, mkWrite(4'h3, 4'hF, 16'h2222), "R9");
    expectEq(dacCode[63:48], 16'h2222, "R9");

    // R4 write then copy all
    cyc(1'b1, mkWrite(4'h2, 4'h1, 16'h3333), "R4");
    expectEq(dacCode[31:16], 16'h3333, "R4");

    // R10 reserved command
    cyc(1'b1, mkWrite(4'h9, 4'h0, 16'h9999), "R10");

    // R11 reset command with a clear edge in the same cycle
    cyc(1'b1, mkFrame(4'h5, 4'h0, 20'h2), "R11");
    presetMid = 1'b0; clearN = 1'b0;
    cyc(1'b1, mkFrame(4'h7, 4'h0, 20'h0), "R11");
    expectEq(dacCode[15:0], 16'h0000, "R11");
    clearN = 1'b1;
    cyc(1'b0, '0, "R1");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] c, a;
      logic [31:0] r;
      r = $urandom;
      c = (r[3:0] < 4'd12) ? {1'b0, r[6:4]} : r[7:4];
      if (c == 4'h7 && r[8]) c = 4'h3;
      a = r[11:9] < 3'd5 ? {2'b00, r[10:9]} : (r[11] ? 4'hF : r[15:12]);
      if (r[20:18] == 3'd0) loadN = ~loadN;
      if (r[23:21] == 3'd0) clearN = ~clearN;
      if (r[27:24] == 4'd0) presetMid = ~presetMid;
      cyc(r[16] | r[17], mkFrame(c, a, $urandom), tagOf(c));
    end
    cyc(1'b0, '0, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule